// File: doc/BRIEF.md
# SPI Register Access Engine

This block is the serial front end of a configuration register file. An external controller drives a four-wire SPI link (nCS, SCLK, SDI, SDO). The block turns each frame into register reads and writes on a simple synchronous register bus. SDO always opens the frame with an 8-bit interrupt status vector. All SPI pins are oversampled by the faster system clock `clk`. All four clock polarity and phase combinations are supported.

The first byte of every frame is a command. Bits 7:1 carry a 7-bit register address and bit 0 selects write (1) or read (0). Three frame formats can be chosen at run time:

- A one-byte format. This is the default.
- A two-byte format that covers two consecutive registers.
- A one-byte format protected by an 8-bit CRC in both directions.

The format, the polynomial and the SPI mode all live in one configuration register at address 0x09. That register is held inside this block; every other address is served by the external register file. A write is applied only after nCS rises at the end of a well-formed frame. Malformed frames set a sticky error output.

Top module: `spi_reg_engine`

## Requirements
- R1: The command byte carries the register address in bits 7:1 and the direction in bit 0 (1 = write, 0 = read). Only the addressed register is changed by a write.
- R2: During the command byte, SDO shifts out, MSB first, the interrupt vector captured when nCS falls. All bytes in both directions are MSB first.
- R3: One-byte format is the default after reset and lasts 16 bits. A read returns the addressed register in the second byte. A write stores the second SDI byte.
- R4: The configuration register at 0x09 resets to 0. Its fields are: bit 0 = CPHA, bit 1 = CPOL, bit 2 = CRC format, bit 3 = two-byte format, bit 4 = alternate polynomial. Reads of 0x09 return it. Writes to 0x09 update it without a register-bus write strobe. It never changes while nCS is low.
- R5: With bit 3 set (this takes priority over bit 2), a frame lasts 24 bits and covers addresses A and A+1, where A+1 wraps modulo 128. A read returns A and then A+1 and ignores SDI after the command. A write stores A and then A+1.
- R6: With bit 2 set and bit 3 clear, a frame lasts 24 bits. A write sends command, data and CRC(command, data), and SDO returns the vector, the value of A before the write, and CRC(vector, that value). A read sends command, filler and CRC(command, filler), and SDO returns the vector, the register, and CRC(vector, register).
- R7: A write is committed only when nCS rises after exactly 16 bits (one-byte format) or 24 bits (other formats). Any other count discards it.
- R8: In CRC format, a write whose received CRC does not match is discarded.
- R9: The CRC starts at 0xFF, runs MSB first, and is XORed with 0xFF at the end. The polynomial is 0x2F, or 0x1D when bit 4 is set.
- R10: `spiErr` goes high on any frame with a wrong bit count or a CRC mismatch. It stays high until reset, and valid frames never set it.
- R11: All four SPI modes transfer data correctly. Data is sampled on the leading clock edge when CPHA = 0 and on the trailing edge when CPHA = 1. The idle level of SCLK equals CPOL.
- R12: SDO is low whenever nCS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI clock |
| sdi | input | 1 | Serial data from the controller |
| sdo | output | 1 | Serial data to the controller |
| intVec | input | 8 | Interrupt status vector sent in the first byte |
| regAddr | output | 7 | Register-bus address |
| regWdata | output | 8 | Register-bus write data |
| regWe | output | 1 | Register-bus write strobe, one cycle per byte written |
| regRdata | input | 8 | Register-bus read data for `regAddr`, same cycle |
| spiErr | output | 1 | Sticky frame error flag |

## Verification
Two decisions meet in the single cycle in which nCS is seen rising after a frame that writes register 0x09. In that cycle the frame's length and CRC are judged, using the format latched at nCS fall and the polynomial still in force. The same cycle also launches the commit that replaces that format and polynomial. The bench provokes this by changing the configuration from inside every format: one-byte to two-byte, two-byte to CRC, CRC with one polynomial to CRC with the other, and CRC back to one-byte. It then judges the outcome from the next frame: the new mode must carry data correctly, and `spiErr` must stay low until the first deliberately bad frame.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  localparam int CFG_CPHA_BIT  = 0;
  localparam int CFG_CPOL_BIT  = 1;
  localparam int CFG_CRC_BIT   = 2;
  localparam int CFG_TWO_BIT   = 3;
  localparam int CFG_POLY_BIT  = 4;

  localparam logic [7:0] POLY_MAIN = 8'h2F;
  localparam logic [7:0] POLY_ALT  = 8'h1D;
  localparam logic [7:0] CRC_SEED  = 8'hFF;

  typedef enum logic [1:0] {
    FMT_ONE = 2'd0,
    FMT_TWO = 2'd1,
    FMT_CRC = 2'd2
  } frameFmt_e;

  // strobes and frame state from control to datapath
  typedef struct packed {
    logic        active;   // nCS low (synchronised)
    logic        start;    // frame begins
    logic        shift;    // SDI bit sampled
    logic        sdiBit;   // sampled bit value
    logic        load;     // a full byte completes with this bit
    logic [1:0]  loadIdx;  // which byte completes
    logic        fetch;    // capture register read data
    logic        commit;   // apply a write
    logic        hiSel;    // second step of a two-register access
    logic [4:0]  pos;      // bits sampled so far
    frameFmt_e   fmt;      // format latched for this frame
  } ctlStrb_t;

  function automatic logic [7:0] crcByte(input logic [7:0] crcIn,
                                         input logic [7:0] din,
                                         input logic [7:0] poly);
    logic [7:0] c;
    c = crcIn;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ din[i]) c = {c[6:0], 1'b0} ^ poly;
      else               c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [7:0] crcPair(input logic [7:0] first,
                                         input logic [7:0] second,
                                         input logic [7:0] poly);
    return crcByte(crcByte(CRC_SEED, first, poly), second, poly) ^ 8'hFF;
  endfunction

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      sdi,
  input  logic      cfgCpol,
  input  logic      cfgCpha,
  input  frameFmt_e cfgFmt,
  input  logic      crcOk,
  output ctlStrb_t  ctl,
  output logic      spiErr
);

  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [4:0] LEN_SHORT = 5'd16;
  localparam logic [4:0] LEN_LONG  = 5'd24;

  logic [LAST:0] csPipe, sclkPipe, sdiPipe;
  logic csS, sclkS, sdiS, csD, sclkD;
  logic frameFall, frameRise, samplePulse;
  logic lenOk, frameOk, secondStep, isWrite;
  ctlStrb_t st;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      csD      <= 1'b1;
      sclkD    <= 1'b0;
    end else begin
      csPipe   <= {csPipe[LAST-1:0], csN};
      sclkPipe <= {sclkPipe[LAST-1:0], sclk};
      sdiPipe  <= {sdiPipe[LAST-1:0], sdi};
      csD      <= csS;
      sclkD    <= sclkS;
    end
  end

  assign csS   = csPipe[LAST];
  assign sclkS = sclkPipe[LAST];
  assign sdiS  = sdiPipe[LAST];

  assign frameFall = csD & ~csS;
  assign frameRise = ~csD & csS;
  // leading edge when CPHA=0, trailing edge when CPHA=1
  assign samplePulse = ~csS & (sclkS ^ sclkD) & (sclkS ^ cfgCpol ^ cfgCpha);

  assign lenOk      = st.pos == ((st.fmt == FMT_ONE) ? LEN_SHORT : LEN_LONG);
  assign frameOk    = lenOk && (st.fmt != FMT_CRC || crcOk);
  assign secondStep = (st.fetch || st.commit) && !st.hiSel && st.fmt == FMT_TWO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= '0;
      isWrite <= 1'b0;
      spiErr  <= 1'b0;
    end else begin
      st.active  <= ~csS;
      st.start   <= frameFall;
      st.shift   <= samplePulse;
      st.sdiBit  <= sdiS;
      st.load    <= samplePulse && st.pos[4:3] != 2'd3 && st.pos[2:0] == 3'd7;
      st.loadIdx <= st.pos[4:3];
      st.fetch   <= (st.load && st.loadIdx == 2'd0) || (st.fetch && secondStep);
      st.commit  <= (frameRise && frameOk && isWrite) || (st.commit && secondStep);
      st.hiSel   <= secondStep;
      if (frameFall) begin
        st.pos <= '0;
        st.fmt <= cfgFmt;
      end else if (samplePulse && st.pos != 5'd31) begin
        st.pos <= st.pos + 5'd1;
      end
      if (samplePulse && st.pos == 5'd7) isWrite <= sdiS;
      if (frameRise && !frameOk) spiErr <= 1'b1;
    end
  end

  assign ctl = st;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    spiErr |=> spiErr); // R10
  AST_COMMIT_LEN: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> (st.pos == LEN_SHORT || st.pos == LEN_LONG)); // R7

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_ADDR = 7'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          ctl,
  input  logic [DATA_W-1:0] intVec,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              sdo,
  output logic              cfgCpol,
  output logic              cfgCpha,
  output frameFmt_e         cfgFmt,
  output logic              crcOk
);

  logic [6:0]        rxShift;
  logic [DATA_W-1:0] cmdB, dat0, dat1, vecHold, tx1, tx2, cfg;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] rdByte, wrByte, byte2, curByte, poly, txCrc;
  logic              hitCfg;

  assign curAddr = cmdB[7:1] + {{(ADDR_W-1){1'b0}}, ctl.hiSel};
  assign hitCfg  = curAddr == CFG_ADDR;
  assign rdByte  = hitCfg ? cfg : regRdata;
  assign wrByte  = ctl.hiSel ? dat1 : dat0;
  assign poly    = cfg[CFG_POLY_BIT] ? POLY_ALT : POLY_MAIN;
  assign txCrc   = crcPair(vecHold, tx1, poly);
  assign crcOk   = crcPair(cmdB, dat0, poly) == dat1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      cmdB    <= '0;
      dat0    <= '0;
      dat1    <= '0;
      vecHold <= '0;
      tx1     <= '0;
      tx2     <= '0;
      cfg     <= '0;
    end else begin
      if (ctl.start) begin
        vecHold <= intVec;
        rxShift <= '0;
      end
      if (ctl.shift) begin
        rxShift <= {rxShift[5:0], ctl.sdiBit};
        if (ctl.load) begin
          case (ctl.loadIdx)
            2'd0:    cmdB <= {rxShift, ctl.sdiBit};
            2'd1:    dat0 <= {rxShift, ctl.sdiBit};
            2'd2:    dat1 <= {rxShift, ctl.sdiBit};
            default: ;
          endcase
        end
      end
      if (ctl.fetch) begin
        if (ctl.hiSel) tx2 <= rdByte;
        else           tx1 <= rdByte;
      end
      if (ctl.commit && hitCfg) cfg <= wrByte;
    end
  end

  assign regAddr  = curAddr;
  assign regWdata = wrByte;
  assign regWe    = ctl.commit && !hitCfg;

  always_comb begin
    case (ctl.fmt)
      FMT_TWO: byte2 = tx2;
      FMT_CRC: byte2 = txCrc;
      default: byte2 = '0;
    endcase
    case (ctl.pos[4:3])
      2'd0:    curByte = vecHold;
      2'd1:    curByte = tx1;
      2'd2:    curByte = byte2;
      default: curByte = '0;
    endcase
  end

  assign sdo = ctl.active & curByte[3'd7 - ctl.pos[2:0]];

  assign cfgCpha = cfg[CFG_CPHA_BIT];
  assign cfgCpol = cfg[CFG_CPOL_BIT];
  assign cfgFmt  = cfg[CFG_TWO_BIT] ? FMT_TWO : (cfg[CFG_CRC_BIT] ? FMT_CRC : FMT_ONE);

  AST_WE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !ctl.active); // R7
  AST_HI_TWO_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hiSel |-> ctl.fmt == FMT_TWO); // R5
  AST_CRC_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && ctl.fmt == FMT_CRC) |-> crcOk); // R8
  AST_CFG_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && $past(ctl.active)) |-> $stable(cfg)); // R4

endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 7'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic [DATA_W-1:0] intVec,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata,
  output logic              spiErr
);

  ctlStrb_t  ctl;
  logic      cfgCpol, cfgCpha, crcOk;
  frameFmt_e cfgFmt;

  spi_reg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgFmt(cfgFmt), .crcOk(crcOk),
    .ctl(ctl), .spiErr(spiErr)
  );

  spi_reg_dp #(.CFG_ADDR(CFG_ADDR)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .intVec(intVec), .regRdata(regRdata),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .sdo(sdo),
    .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgFmt(cfgFmt), .crcOk(crcOk)
  );

endmodule

// File: tb/sim_spi_reg_engine.sv
module sim_spi_reg_engine;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, csN, sclk, sdi, sdo, regWe, spiErr;
  logic [7:0] intVec, regWdata, regRdata;
  logic [6:0] regAddr;

  spi_reg_engine u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .intVec(intVec), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata), .spiErr(spiErr)
  );

  logic [7:0] mem [128];
  logic [7:0] expMem [128];
  assign regRdata = mem[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) mem[i] <= (i == 9) ? 8'hEE : 8'(i * 3 + 1);
    end else if (regWe) begin
      mem[regAddr] <= regWdata;
    end
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] cfgVal = 8'h00;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] crcB(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] c, p;
    p = cfgVal[4] ? 8'h1D : 8'h2F;
    c = 8'hFF;
    for (int k = 0; k < 2; k++) begin
      for (int i = 7; i >= 0; i--) begin
        if (c[7] ^ ((k == 0) ? a[i] : b[i])) c = {c[6:0], 1'b0} ^ p;
        else c = {c[6:0], 1'b0};
      end
    end
    return c ^ 8'hFF;
  endfunction

  function automatic int frameLen();
    return (cfgVal[3] || cfgVal[2]) ? 24 : 16;
  endfunction

  task automatic xfer(input int n, input logic [23:0] mo, output logic [23:0] mi);
    mi = '0;
    sclk = cfgVal[1];
    repeat (4) @(negedge clk);
    csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      if (!cfgVal[0]) begin
        sdi = mo[23-i];
        repeat (8) @(negedge clk);
        mi[23-i] = sdo;
        sclk = ~sclk;
        repeat (8) @(negedge clk);
        sclk = ~sclk;
      end else begin
        sclk = ~sclk;
        sdi = mo[23-i];
        repeat (8) @(negedge clk);
        mi[23-i] = sdo;
        sclk = ~sclk;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic spiWrite(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input bit badCrc, input int nForce, output logic [23:0] mi);
    logic [7:0] cmd, third;
    int n;
    cmd = {a, 1'b1};
    n = (nForce > 0) ? nForce : frameLen();
    if (cfgVal[3]) third = d1;
    else if (cfgVal[2]) third = crcB(cmd, d0) ^ {7'b0, badCrc};
    else third = 8'h00;
    xfer(n, {cmd, d0, third}, mi);
  endtask

  task automatic spiRead(input logic [6:0] a, output logic [23:0] mi);
    logic [7:0] cmd;
    cmd = {a, 1'b0};
    xfer(frameLen(), {cmd, 8'h00, (!cfgVal[3] && cfgVal[2]) ? crcB(cmd, 8'h00) : 8'h00}, mi);
  endtask

  task automatic setCfg(input logic [7:0] v);
    logic [23:0] mi;
    spiWrite(7'h09, v, expMem[10], 1'b0, 0, mi);
    cfgVal = v;
    sclk = cfgVal[1];
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] mi;
    logic [6:0] addrs [4];
    logic [7:0] v, prior;
    addrs[0] = 7'h00; addrs[1] = 7'h10; addrs[2] = 7'h2A; addrs[3] = 7'h7F;
    for (int i = 0; i < 128; i++) expMem[i] = (i == 9) ? 8'hEE : 8'(i * 3 + 1);
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0; intVec = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    chk(sdo == 1'b0, "R12 sdo idle after reset", 32'(sdo), 0);
    chk(spiErr == 1'b0, "R10 error clear after reset", 32'(spiErr), 0);

    intVec = 8'hA5;
    spiRead(7'h09, mi);
    chk(mi[23:16] == 8'hA5, "R2 vector in first byte", 32'(mi[23:16]), 32'hA5);
    chk(mi[15:8] == 8'h00, "R4 config resets to zero", 32'(mi[15:8]), 0);

    // sweep of all SPI modes in one-byte format
    for (int m = 0; m < 4; m++) begin
      setCfg(8'(m));
      for (int ai = 0; ai < 4; ai++) begin
        v = 8'(addrs[ai] * 7) ^ 8'(m * 8'h33) ^ 8'hC5;
        intVec = {1'b1, addrs[ai]} ^ 8'(m << 4);
        spiWrite(addrs[ai], v, 8'h00, 1'b0, 0, mi);
        expMem[addrs[ai]] = v;
        chk(mem[addrs[ai]] == v, "R3 one-byte write stored", 32'(mem[addrs[ai]]), 32'(v));
        chk(mi[23:16] == intVec, "R2 vector during write", 32'(mi[23:16]), 32'(intVec));
        chk(mem[7'(addrs[ai] + 7'd1)] == expMem[7'(addrs[ai] + 7'd1)], "R1 neighbour untouched",
            32'(mem[7'(addrs[ai] + 7'd1)]), 32'(expMem[7'(addrs[ai] + 7'd1)]));
        spiRead(addrs[ai], mi);
        chk(mi[15:8] == v, "R11 readback in this SPI mode", 32'(mi[15:8]), 32'(v));
      end
      spiRead(7'h09, mi);
      chk(mi[15:8] == 8'(m), "R4 config readback", 32'(mi[15:8]), 32'(m));
    end
    chk(mem[9] == 8'hEE, "R4 config write kept off the bus", 32'(mem[9]), 32'hEE);

    // two-byte format, mode 3; config change out of one-byte format
    setCfg(8'h0B);
    intVec = 8'h3C;
    spiWrite(7'h7F, 8'h5C, 8'hD3, 1'b0, 0, mi);
    expMem[127] = 8'h5C; expMem[0] = 8'hD3;
    chk(mem[127] == 8'h5C, "R5 two-byte first register", 32'(mem[127]), 32'h5C);
    chk(mem[0] == 8'hD3, "R5 two-byte wrap to address 0", 32'(mem[0]), 32'hD3);
    spiRead(7'h7F, mi);
    chk(mi[15:8] == 8'h5C && mi[7:0] == 8'hD3, "R5 two-byte read pair", 32'(mi[15:0]), 32'h5CD3);
    chk(mi[23:16] == 8'h3C, "R2 vector in two-byte frame", 32'(mi[23:16]), 32'h3C);
    xfer(24, {7'h20, 1'b0, 8'hFF, 8'hFF}, mi);
    chk(mi[15:0] == {expMem[32], expMem[33]}, "R5 read ignores SDI data", 32'(mi[15:0]),
        32'({expMem[32], expMem[33]}));
    chk(mem[32] == expMem[32], "R5 read leaves register", 32'(mem[32]), 32'(expMem[32]));

    // CRC format, default polynomial, mode 1
    setCfg(8'h05);
    intVec = 8'h96;
    prior = expMem[51];
    spiWrite(7'h33, 8'h6E, 8'h00, 1'b0, 0, mi);
    expMem[51] = 8'h6E;
    chk(mi[15:8] == prior, "R6 write returns prior value", 32'(mi[15:8]), 32'(prior));
    chk(mi[7:0] == crcB(8'h96, prior), "R9 CRC 0x2F on SDO", 32'(mi[7:0]), 32'(crcB(8'h96, prior)));
    chk(mem[51] == 8'h6E, "R6 CRC write stored", 32'(mem[51]), 32'h6E);
    spiRead(7'h33, mi);
    chk(mi[15:8] == 8'h6E, "R6 CRC read data", 32'(mi[15:8]), 32'h6E);
    chk(mi[7:0] == crcB(8'h96, 8'h6E), "R6 CRC read check byte", 32'(mi[7:0]), 32'(crcB(8'h96, 8'h6E)));

    // CRC format, alternate polynomial, mode 2
    setCfg(8'h16);
    intVec = 8'h41;
    prior = expMem[68];
    spiWrite(7'h44, 8'hB7, 8'h00, 1'b0, 0, mi);
    expMem[68] = 8'hB7;
    chk(mi[7:0] == crcB(8'h41, prior), "R9 CRC 0x1D on SDO", 32'(mi[7:0]), 32'(crcB(8'h41, prior)));
    chk(mem[68] == 8'hB7, "R9 write with 0x1D CRC stored", 32'(mem[68]), 32'hB7);
    spiRead(7'h44, mi);
    chk(mi[15:8] == 8'hB7 && mi[7:0] == crcB(8'h41, 8'hB7), "R9 read with 0x1D CRC",
        32'(mi[15:0]), 32'({8'hB7, crcB(8'h41, 8'hB7)}));
    chk(spiErr == 1'b0, "R10 no error on valid frames", 32'(spiErr), 0);

    spiWrite(7'h44, 8'h99, 8'h00, 1'b1, 0, mi);
    chk(mem[68] == 8'hB7, "R8 bad CRC write discarded", 32'(mem[68]), 32'hB7);
    chk(spiErr == 1'b1, "R10 error set by bad CRC", 32'(spiErr), 1);

    // back to one-byte mode 0
    setCfg(8'h00);
    spiRead(7'h09, mi);
    chk(mi[15:8] == 8'h00, "R4 config left CRC format", 32'(mi[15:8]), 0);
    spiWrite(7'h50, 8'h12, 8'h00, 1'b0, 15, mi);
    chk(mem[80] == expMem[80], "R7 short frame discarded", 32'(mem[80]), 32'(expMem[80]));
    spiWrite(7'h50, 8'h34, 8'h00, 1'b0, 17, mi);
    chk(mem[80] == expMem[80], "R7 long frame discarded", 32'(mem[80]), 32'(expMem[80]));
    spiWrite(7'h50, 8'h56, 8'h00, 1'b0, 0, mi);
    chk(mem[80] == 8'h56, "R7 exact frame committed", 32'(mem[80]), 32'h56);
    chk(spiErr == 1'b1, "R10 error stays set", 32'(spiErr), 1);
    chk(sdo == 1'b0, "R12 sdo idle between frames", 32'(sdo), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule